// File: doc/BRIEF.md
# Scan-Path Memory Access Register with Streaming Transfer

This block sits behind a test access port and gives its serial shift path a way into a 1024-word by 16-bit memory. It works in one of two framings chosen by a mode input. In addressed framing the shift path is 26 bits long. It holds a 10-bit location and a 16-bit word. An update strobe stores the location and, for writes, stores the word there. A capture strobe loads the word at the stored location back into the chain.

In streaming framing the chain shrinks to the 16 data bits alone, and the location steps forward by itself after each word. A read stream fetches the first word on capture. It fetches each following word in the same cycle that the last bit of the previous word leaves on the serial output, so the output carries no gap. A write stream stays idle until it is armed. Arming happens either through a start pulse from the port controller or when the eight most recent serial input bits equal a nonzero header value. After that, every sixteenth shifted bit completes a word, which is written and the location advanced.

The port state machine that produces the capture, shift and update strobes is outside this block. The memory sits outside too. It is reached through a port whose read data is expected in the same cycle as the address.

Top module: `scan_mem_dma`

## Requirements
- R1: During and just after reset the serial output is 0 and neither memory write enable nor memory read enable is asserted.
- R2: With streaming mode low the chain is 26 bits, shifted least significant bit first. Bits 9:0 hold the location and bits 25:10 the word. The serial output is chain bit 0, so bits shifted in appear at the output 26 shifts later.
- R3: With streaming mode low, an update strobe with write direction high writes chain bits 25:10 to location chain bits 9:0. With write direction low no write happens, and only the location is stored.
- R4: With streaming mode low, a capture strobe loads the chain with the word at the stored location in bits 25:10 and that location in bits 9:0.
- R5: With streaming mode high and no read active, the chain is 16 bits, and a bit shifted in appears at the serial output 16 shifts later.
- R6: With streaming mode high and write direction low, a capture reads the stored location and the location advances by one. Each sixteenth following shift loads the next word in the same cycle. The serial output therefore presents consecutive words back to back, least significant bit first.
- R7: An armed write stream writes one word on every sixteenth shift after arming, at consecutive locations starting from the stored one. The word's bit 0 is the first bit shifted after arming.
- R8: The header window holds the last 8 serial input bits, with the earliest of them as bit 0, and is cleared by reset and by an update strobe. The stream arms on the shift where the window equals a nonzero header value, provided streaming mode and write direction are high. In read direction a matching header causes no write.
- R9: A header value of 00h never arms the stream from the serial data. A start pulse arms it regardless of the header value.
- R10: The streaming location wraps from 3FFh to 000h, for both reads and writes.
- R11: An update strobe disarms a write stream. A partly shifted word is dropped, and later shifts write nothing until the stream is armed again.
- R12: Memory write enable and memory read enable are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_en | input | 1 | Capture strobe from the port controller |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| update_en | input | 1 | Update strobe from the port controller |
| tdi | input | 1 | Serial data in |
| stream_mode | input | 1 | 1 selects streaming framing, 0 selects addressed framing |
| wr_dir | input | 1 | 1 selects write, 0 selects read |
| tap_start | input | 1 | Start pulse that arms a write stream |
| header_val | input | 8 | Header pattern; 00h turns off stream arming |
| tdo | output | 1 | Serial data out |
| mem_addr | output | 10 | Memory location |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data for mem_addr, same cycle |

## Verification
The bound checker checks on every cycle that write and read enables never overlap. It also checks that streaming writes happen only on a shift with write direction set, and that a streaming read never occurs in write direction. Finally it checks that, unless an update or a mode change intervenes, a streaming access is followed by the next location with wrap at the top. Only the bench scenarios can show the rest: where the header window arms within a random bit stream, and the assembled word contents. They also cover the 16-shift and 26-shift delays, dropping of a partial word, the absence of writes when the header is 00h or the direction is read, and gap-free read words across the 3FFh-to-000h wrap.

// File: rtl/scanmem_pkg.sv
package scanmem_pkg;

    localparam int SM_ADDR_W = 10;
    localparam int SM_DATA_W = 16;
    localparam int SM_HDR_W  = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_READ  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
        logic stream;
        logic wr_dir;
    } scan_ctl_t;

    function automatic logic is_stream_wr(input scan_ctl_t c);
        return c.stream && c.wr_dir;
    endfunction

    function automatic logic is_stream_rd(input scan_ctl_t c);
        return c.stream && !c.wr_dir;
    endfunction

endpackage

// File: rtl/sm_hdr_window.sv
module sm_hdr_window #(
    parameter int HDR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             clear,
    input  logic             tdi,
    input  logic [HDR_W-1:0] header,
    output logic             hit
);
    logic [HDR_W-1:0] win_q;
    logic [HDR_W-1:0] win_nxt;

    // newest bit enters at the top, the earliest of the window sits at bit 0
    assign win_nxt = {tdi, win_q[HDR_W-1:1]};
    assign hit     = shift && (header != '0) && (win_nxt == header);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win_q <= '0;
        end else if (shift) begin
            win_q <= win_nxt;
        end
    end
endmodule

// File: rtl/sm_chain.sv
module sm_chain
    import scanmem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  scan_ctl_t                ctl,
    input  logic                     tdi,
    input  logic                     load_word,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W+DATA_W-1:0] chain,
    output logic                     tdo
);
    localparam int CHAIN_W = ADDR_W + DATA_W;

    logic [CHAIN_W-1:0] chain_q;

    assign chain = chain_q;
    assign tdo   = chain_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (ctl.capture && !ctl.stream) begin
            chain_q <= {rdata, addr_q};
        end else if (load_word) begin
            chain_q[DATA_W-1:0] <= rdata;
        end else if (ctl.shift) begin
            if (ctl.stream) begin
                chain_q[DATA_W-1:0] <= {tdi, chain_q[DATA_W-1:1]};
            end else begin
                chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/sm_seq.sv
module sm_seq
    import scanmem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  scan_ctl_t                ctl,
    input  logic                     tap_start,
    input  logic                     hdr_hit,
    input  logic                     tdi,
    input  logic [ADDR_W+DATA_W-1:0] chain,
    output logic [ADDR_W-1:0]        addr_q,
    output logic                     load_word,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_we,
    output logic                     mem_re,
    output logic [DATA_W-1:0]        mem_wdata
);
    localparam int CHAIN_W = ADDR_W + DATA_W;
    localparam int CNT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    seq_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             upd_addr;
    logic             word_end;
    logic             wr_fire;
    logic             rd_fetch;
    logic             arm;

    always_comb begin
        upd_addr  = ctl.update && !ctl.stream;
        word_end  = ctl.shift && (cnt_q == LAST_BIT);
        wr_fire   = (st_q == SEQ_WRITE) && is_stream_wr(ctl) && word_end;
        rd_fetch  = is_stream_rd(ctl) && (ctl.capture || ((st_q == SEQ_READ) && word_end));
        arm       = (st_q == SEQ_IDLE) && is_stream_wr(ctl) && (tap_start || hdr_hit);
        load_word = rd_fetch;

        mem_we    = (upd_addr && ctl.wr_dir) || wr_fire;
        mem_re    = rd_fetch || (ctl.capture && !ctl.stream);
        mem_addr  = upd_addr ? chain[ADDR_W-1:0] : addr_q;
        mem_wdata = upd_addr ? chain[CHAIN_W-1:ADDR_W] : {tdi, chain[DATA_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (ctl.update) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
            if (upd_addr) begin
                addr_q <= chain[ADDR_W-1:0];
            end
        end else if (rd_fetch) begin
            st_q   <= SEQ_READ;
            cnt_q  <= '0;
            addr_q <= addr_q + 1'b1;
        end else if (arm) begin
            st_q  <= SEQ_WRITE;
            cnt_q <= '0;
        end else if (wr_fire) begin
            cnt_q  <= '0;
            addr_q <= addr_q + 1'b1;
        end else if (ctl.shift && (st_q != SEQ_IDLE)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scan_mem_dma.sv
module scan_mem_dma
    import scanmem_pkg::*;
#(
    parameter int ADDR_W = SM_ADDR_W,
    parameter int DATA_W = SM_DATA_W,
    parameter int HDR_W  = SM_HDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              tdi,
    input  logic              stream_mode,
    input  logic              wr_dir,
    input  logic              tap_start,
    input  logic [HDR_W-1:0]  header_val,
    output logic              tdo,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CHAIN_W = ADDR_W + DATA_W;

    scan_ctl_t          ctl;
    logic               hdr_hit;
    logic               load_word;
    logic [ADDR_W-1:0]  addr_q;
    logic [CHAIN_W-1:0] chain;

    always_comb begin
        ctl.capture = capture_en;
        ctl.shift   = shift_en;
        ctl.update  = update_en;
        ctl.stream  = stream_mode;
        ctl.wr_dir  = wr_dir;
    end

    sm_hdr_window #(.HDR_W(HDR_W)) u_hdr (
        .clk    (clk),
        .rst    (rst),
        .shift  (shift_en),
        .clear  (update_en),
        .tdi    (tdi),
        .header (header_val),
        .hit    (hdr_hit)
    );

    sm_chain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .tdi       (tdi),
        .load_word (load_word),
        .addr_q    (addr_q),
        .rdata     (mem_rdata),
        .chain     (chain),
        .tdo       (tdo)
    );

    sm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .tap_start (tap_start),
        .hdr_hit   (hdr_hit),
        .tdi       (tdi),
        .chain     (chain),
        .addr_q    (addr_q),
        .load_word (load_word),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              capture_en,
    input logic              shift_en,
    input logic              update_en,
    input logic              stream_mode,
    input logic              wr_dir,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re
);
    logic [ADDR_W-1:0] addr_nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_nxt_q <= '0;
        end else begin
            addr_nxt_q <= mem_addr + 1'b1;
        end
    end

    // R12
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R7
    stream_write_on_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && stream_mode) |-> (shift_en && wr_dir));

    // R6
    stream_read_direction_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && stream_mode) |-> !wr_dir);

    // R10
    stream_write_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && stream_mode) |=>
            (update_en || capture_en || !stream_mode || mem_addr == addr_nxt_q));

    // R10
    stream_read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && stream_mode) |=>
            (update_en || !stream_mode || wr_dir || mem_addr == addr_nxt_q));
endmodule

bind scan_mem_dma sm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .capture_en  (capture_en),
    .shift_en    (shift_en),
    .update_en   (update_en),
    .stream_mode (stream_mode),
    .wr_dir      (wr_dir),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .mem_re      (mem_re)
);

// File: tb/scan_mem_dma_test.sv
module scan_mem_dma_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, capture_en, shift_en, update_en, tdi;
    logic        stream_mode, wr_dir, tap_start;
    logic [7:0]  header_val;
    logic        tdo, mem_we, mem_re;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem     [0:1023];
    logic [15:0] exp_mem [0:1023];
    logic        sbits   [0:255];
    logic        sout    [0:255];
    int          errors = 0;
    int          checks = 0;
    int          wr_count = 0;
    int          clash_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_mem_dma uut (
        .clk(clk), .rst(rst), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .stream_mode(stream_mode), .wr_dir(wr_dir),
        .tap_start(tap_start), .header_val(header_val), .tdo(tdo), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_count++;
            end
            if (mem_we && mem_re) clash_count++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scan_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            shift_en = 1'b1;
            tdi = din[i];
            dout[i] = tdo;
        end
        @(negedge clk);
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic scan_stream(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            shift_en = 1'b1;
            tdi = sbits[i];
            sout[i] = tdo;
        end
        @(negedge clk);
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_update();
        @(negedge clk); update_en = 1'b1;
        @(negedge clk); update_en = 1'b0;
    endtask

    task automatic do_capture();
        @(negedge clk); capture_en = 1'b1;
        @(negedge clk); capture_en = 1'b0;
    endtask

    task automatic do_tap_start();
        @(negedge clk); tap_start = 1'b1;
        @(negedge clk); tap_start = 1'b0;
    endtask

    task automatic set_addr(input logic [9:0] a);
        logic [63:0] d;
        stream_mode = 1'b0;
        wr_dir = 1'b0;
        scan_bits(26, {38'h0, 16'h0, a}, d);
        do_update();
    endtask

    task automatic addr_write(input logic [9:0] a, input logic [15:0] v);
        logic [63:0] d;
        stream_mode = 1'b0;
        wr_dir = 1'b1;
        scan_bits(26, {38'h0, v, a}, d);
        do_update();
        wr_dir = 1'b0;
        exp_mem[a] = v;
    endtask

    function automatic logic [15:0] word_of(input int base);
        logic [15:0] w;
        for (int j = 0; j < 16; j++) w[j] = sout[base + j];
        return w;
    endfunction

    // expected write list from the header-arming rule, window cleared beforehand
    logic [9:0] mw_addr [0:15];
    int         mw_n;
    task automatic model_hdr_write(input int n, input logic [7:0] hdr, input logic [9:0] start);
        logic [7:0]  win = '0;
        logic [15:0] w = '0;
        logic [9:0]  a = start;
        bit          armed = 1'b0;
        int          cnt = 0;
        mw_n = 0;
        for (int i = 0; i < n; i++) begin
            if (!armed) begin
                win = {sbits[i], win[7:1]};
                if (win == hdr) armed = 1'b1;
            end else begin
                w[cnt] = sbits[i];
                cnt++;
                if (cnt == 16) begin
                    exp_mem[a] = w;
                    mw_addr[mw_n] = a;
                    mw_n++;
                    a = a + 10'd1;
                    cnt = 0;
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] d, v, o;
        logic [9:0]  a;
        logic [15:0] w;
        logic [7:0]  hdr;
        int          base_wr;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 16'h0;
            exp_mem[i] = 16'h0;
        end
        rst = 1'b1; capture_en = 0; shift_en = 0; update_en = 0; tdi = 0;
        stream_mode = 0; wr_dir = 0; tap_start = 0; header_val = 8'h00;
        repeat (3) @(negedge clk);
        check(tdo == 1'b0 && !mem_we && !mem_re, "R1 in reset", {tdo, mem_we, mem_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tdo == 1'b0 && !mem_we && !mem_re, "R1 after reset", {tdo, mem_we, mem_re}, 0);

        // addressed writes, random plus the top location
        for (int k = 0; k < 6; k++) begin
            a = (k == 0) ? 10'h3FF : 10'($urandom_range(1, 1000));
            w = 16'($urandom);
            addr_write(a, w);
            check(mem[a] == w, "R3 addressed write", mem[a], w);
        end
        // read direction update stores no data
        base_wr = wr_count;
        set_addr(10'h155);
        check(wr_count == base_wr, "R3 read update writes nothing", wr_count, base_wr);

        // addressed reads
        for (int k = 0; k < 4; k++) begin
            a = (k == 0) ? 10'h3FF : 10'($urandom_range(0, 1023));
            if (k == 1) a = 10'h155;
            set_addr(a);
            do_capture();
            scan_bits(26, 64'($urandom), o);
            check(o[9:0] == a, "R4 captured location", o[9:0], a);
            check(o[25:10] == exp_mem[a], "R4 captured word", o[25:10], exp_mem[a]);
        end

        // 26-bit delay in addressed framing
        v = {32'h0, 32'($urandom)} & 64'h3FF_FFFF;
        scan_bits(26, v, o);
        scan_bits(26, 64'h0, o);
        check(o[25:0] == v[25:0], "R2 26-bit chain", o[25:0], v[25:0]);

        // streaming passthrough with header 00h: 16-bit delay, no writes
        base_wr = wr_count;
        stream_mode = 1'b1; wr_dir = 1'b1; header_val = 8'h00;
        for (int i = 0; i < 40; i++) sbits[i] = 1'($urandom);
        scan_stream(40);
        begin
            bit ok = 1'b1;
            for (int i = 16; i < 40; i++) if (sout[i] !== sbits[i-16]) ok = 1'b0;
            check(ok, "R5 16-bit stream delay", ok, 1);
        end
        check(wr_count == base_wr, "R9 header 00h never arms", wr_count, base_wr);

        // start pulse write across the wrap
        set_addr(10'h3FE);
        stream_mode = 1'b1; wr_dir = 1'b1; header_val = 8'h00;
        base_wr = wr_count;
        do_tap_start();
        for (int i = 0; i < 48; i++) sbits[i] = 1'($urandom);
        scan_stream(48);
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 16; j++) w[j] = sbits[k*16 + j];
            a = 10'h3FE + 10'(k);
            exp_mem[a] = w;
            check(mem[a] == w, "R7 R10 start pulse stream write", mem[a], w);
        end
        check(wr_count == base_wr + 3, "R9 start pulse arms", wr_count, base_wr + 3);
        do_update();

        // partial word dropped on update
        addr_write(10'h051, 16'hBEEF);
        set_addr(10'h050);
        stream_mode = 1'b1; wr_dir = 1'b1;
        base_wr = wr_count;
        do_tap_start();
        for (int i = 0; i < 23; i++) sbits[i] = 1'($urandom);
        scan_stream(23);
        do_update();
        for (int j = 0; j < 16; j++) w[j] = sbits[j];
        exp_mem[10'h050] = w;
        check(mem[10'h050] == w, "R11 full word written", mem[10'h050], w);
        check(mem[10'h051] == 16'hBEEF, "R11 partial word dropped", mem[10'h051], 16'hBEEF);
        for (int i = 0; i < 32; i++) sbits[i] = 1'($urandom);
        scan_stream(32);
        check(wr_count == base_wr + 1, "R11 disarmed after update", wr_count, base_wr + 1);

        // header-triggered writes in random streams
        for (int t = 0; t < 3; t++) begin
            hdr = 8'($urandom_range(1, 255));
            a = 10'($urandom_range(0, 1023));
            set_addr(a);
            stream_mode = 1'b1; wr_dir = 1'b1; header_val = hdr;
            for (int i = 0; i < 12; i++) sbits[i] = 1'($urandom);
            for (int i = 0; i < 8; i++) sbits[12 + i] = hdr[i];
            for (int i = 20; i < 55; i++) sbits[i] = 1'($urandom);
            base_wr = wr_count;
            model_hdr_write(55, hdr, a);
            scan_stream(55);
            do_update();
            check(wr_count == base_wr + mw_n, "R8 header arming write count", wr_count, base_wr + mw_n);
            for (int k = 0; k < mw_n; k++)
                check(mem[mw_addr[k]] == exp_mem[mw_addr[k]], "R8 R7 header stream word",
                      mem[mw_addr[k]], exp_mem[mw_addr[k]]);
        end

        // matching header in read direction writes nothing
        hdr = 8'hA7;
        set_addr(10'h200);
        stream_mode = 1'b1; wr_dir = 1'b0; header_val = hdr;
        for (int i = 0; i < 8; i++) sbits[i] = 1'b0;
        for (int i = 0; i < 8; i++) sbits[8 + i] = hdr[i];
        for (int i = 16; i < 48; i++) sbits[i] = 1'($urandom);
        base_wr = wr_count;
        scan_stream(48);
        check(wr_count == base_wr, "R8 header ignored in read direction", wr_count, base_wr);

        // streaming reads, one across the wrap
        for (int t = 0; t < 2; t++) begin
            a = (t == 0) ? 10'h3FE : 10'h050;
            set_addr(a);
            stream_mode = 1'b1; wr_dir = 1'b0;
            do_capture();
            for (int i = 0; i < 48; i++) sbits[i] = 1'b0;
            scan_stream(48);
            for (int k = 0; k < 3; k++)
                check(word_of(k*16) == exp_mem[a + 10'(k)], "R6 R10 streaming read word",
                      word_of(k*16), exp_mem[a + 10'(k)]);
        end

        check(clash_count == 0, "R12 no read-write overlap", clash_count, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule